// File: doc/BRIEF.md
# Counting Bloom Frequency Estimator

This block keeps an approximate count of how often each block-aligned address has missed in the main cache. It holds five banks of small saturating counters. Each bank is indexed by its own bit slice of the address, and the slices differ in position and width. An increment request bumps the one addressed counter in every bank. An estimate request reads the five addressed counters in parallel. Two cycles later it returns the smallest of them, which limits the overcount caused by aliasing in any single bank.

Counters stop at their maximum value instead of wrapping. The block counts how many counters have newly reached that maximum. When the count reaches a configured threshold, the block sweeps through the banks and zeroes every counter. During the sweep `busy_o` is high and new requests are not taken; a caller retries them after `busy_o` falls. The surrounding cache, the victim structure and the replacement decision are outside this block.

Top module: `freq_estimator`

## Requirements
- R1: After reset, `busy_o` and `est_valid_o` are low and every counter is zero, so any estimate returns 0.
- R2: Bank b is indexed by `addr[SLICE_LSB[b] +: SLICE_W[b]]`. The defaults are bits 4..14 (the upper part of the low 15 bits), 15..22, 23..25, 9..18 and 19..24.
- R3: An estimate request taken in cycle k (`est_valid_i` high, `busy_o` low) raises `est_valid_o` for exactly one cycle, in cycle k+2.
- R4: `est_value_o` is the minimum of the five counters addressed by the estimate address.
- R5: An increment request taken while `busy_o` is low adds one to the addressed counter in each of the five banks.
- R6: A counter at 2^CNT_W-1 stays there when incremented again.
- R7: When an increment and an estimate are taken in the same cycle, the estimate reflects the counters as they were before that increment.
- R8: A counter adds one to the saturation tally only on the increment that moves it from 2^CNT_W-2 to 2^CNT_W-1. The increment that brings the tally to SAT_THRESH or more starts a clear, and `busy_o` is high from the next cycle.
- R9: A clear keeps `busy_o` high for exactly 2^max(SLICE_W) cycles. Afterwards every counter and the tally are zero.
- R10: While `busy_o` is high, increment and estimate requests are ignored: no counter changes and no `est_valid_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inc_valid_i | input | 1 | Increment request (miss in the main cache) |
| inc_addr_i | input | ADDR_W | Address to count |
| est_valid_i | input | 1 | Estimate request |
| est_addr_i | input | ADDR_W | Address to estimate |
| busy_o | output | 1 | Clear sweep in progress; requests are not taken |
| est_valid_o | output | 1 | Estimate result valid |
| est_value_o | output | CNT_W | Minimum of the addressed counters |

## Verification
The bench uses a narrow configuration: 3-bit counters, slices of 2 to 3 bits and a low threshold. This makes saturation, the tally and the clear sweep occur many times. One address is hammered past saturation. A design that wraps would then report a small value, and one that counts the same counter more than once would start the clear early. Same-cycle increment and estimate pairs catch a design that forwards the new value. Requests issued during the sweep catch a design that leaks a counter update or a result through `busy_o`. The length of each sweep and the all-zero state after it are checked every time a sweep happens, so an off-by-one sweep or a leftover count shows up.

// File: rtl/freq_est_pkg.sv
package freq_est_pkg;
  localparam int unsigned NUM_BANKS = 5;

  function automatic int unsigned widest(input int unsigned w [NUM_BANKS]);
    int unsigned m = 0;
    for (int i = 0; i < NUM_BANKS; i++) if (w[i] > m) m = w[i];
    return m;
  endfunction
endpackage

// File: rtl/fe_bank.sv
module fe_bank #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CLR_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] inc_idx_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             clr_i,
  input  logic [CLR_W-1:0] clr_idx_i,
  output logic             sat_new_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cur;

  assign cur       = cnt_q[inc_idx_i];
  assign sat_new_o = inc_i && (cur == CNT_NEAR);

  // narrower banks are swept several times over by the wide clear index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (clr_i) begin
      cnt_q[clr_idx_i[IDX_W-1:0]] <= '0;
    end else if (inc_i && (cur != CNT_MAX)) begin
      cnt_q[inc_idx_i] <= cur + CNT_W'(1);
    end
  end

  // read samples the pre-increment value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= cnt_q[rd_idx_i];
  end
endmodule

// File: rtl/fe_min_tree.sv
module fe_min_tree #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i [N],
  output logic [W-1:0] min_o
);
  always_comb begin
    min_o = val_i[0];
    for (int i = 1; i < N; i++) if (val_i[i] < min_o) min_o = val_i[i];
  end
endmodule

// File: rtl/fe_clear_ctrl.sv
module fe_clear_ctrl #(
  parameter int unsigned NB         = 5,
  parameter int unsigned SAT_THRESH = 64,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    sat_new_i,
  output logic             clearing_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  localparam int unsigned TALLY_W = $clog2(SAT_THRESH + NB + 1);

  logic [TALLY_W-1:0] tally_q, tally_sum;
  logic               trigger;

  assign tally_sum = tally_q + TALLY_W'($countones(sat_new_i));
  assign trigger   = !clearing_o && (tally_sum >= TALLY_W'(SAT_THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tally_q    <= '0;
      clearing_o <= 1'b0;
      clr_idx_o  <= '0;
    end else if (clearing_o) begin
      clr_idx_o <= clr_idx_o + IDX_W'(1);
      if (clr_idx_o == '1) clearing_o <= 1'b0;
    end else if (trigger) begin
      clearing_o <= 1'b1;
      clr_idx_o  <= '0;
      tally_q    <= '0;
    end else begin
      tally_q <= tally_sum;
    end
  end
endmodule

// File: rtl/freq_estimator.sv
module freq_estimator
  import freq_est_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SAT_THRESH = 64,
  parameter int unsigned SLICE_LSB [NUM_BANKS] = '{4, 15, 23, 9, 19},
  parameter int unsigned SLICE_W   [NUM_BANKS] = '{11, 8, 3, 10, 6}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_valid_i,
  input  logic [ADDR_W-1:0] inc_addr_i,
  input  logic              est_valid_i,
  input  logic [ADDR_W-1:0] est_addr_i,
  output logic              busy_o,
  output logic              est_valid_o,
  output logic [CNT_W-1:0]  est_value_o
);
  localparam int unsigned IDX_W = widest(SLICE_W);

  logic                 inc_go, est_go, rd_vld_q;
  logic [IDX_W-1:0]     clr_idx;
  logic [NUM_BANKS-1:0] sat_new;
  logic [CNT_W-1:0]     rd_val [NUM_BANKS];
  logic [CNT_W-1:0]     min_val;

  assign inc_go = inc_valid_i && !busy_o;
  assign est_go = est_valid_i && !busy_o;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    fe_bank #(
      .IDX_W(SLICE_W[g]),
      .CLR_W(IDX_W),
      .CNT_W(CNT_W)
    ) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc_go),
      .inc_idx_i(inc_addr_i[SLICE_LSB[g] +: SLICE_W[g]]),
      .rd_i     (est_go),
      .rd_idx_i (est_addr_i[SLICE_LSB[g] +: SLICE_W[g]]),
      .rd_data_o(rd_val[g]),
      .clr_i    (busy_o),
      .clr_idx_i(clr_idx),
      .sat_new_o(sat_new[g])
    );
  end

  fe_min_tree #(.N(NUM_BANKS), .W(CNT_W)) i_min (
    .val_i(rd_val),
    .min_o(min_val)
  );

  fe_clear_ctrl #(
    .NB        (NUM_BANKS),
    .SAT_THRESH(SAT_THRESH),
    .IDX_W     (IDX_W)
  ) i_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sat_new_i (sat_new),
    .clearing_o(busy_o),
    .clr_idx_o (clr_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q    <= 1'b0;
      est_valid_o <= 1'b0;
      est_value_o <= '0;
    end else begin
      rd_vld_q    <= est_go;
      est_valid_o <= rd_vld_q;
      if (rd_vld_q) est_value_o <= min_val;
    end
  end
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CLR_CYC = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             est_valid_i,
  input logic             busy_o,
  input logic             est_valid_o,
  input logic [CNT_W-1:0] est_value_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  assert_est_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_valid_i && !busy_o) |-> ##2 est_valid_o);

  assert_busy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_valid_i && busy_o) |-> ##2 !est_valid_o);

  assert_clear_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < CLR_CYC));

  assert_clear_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == CLR_CYC));

  assert_cleared_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && est_valid_i) |-> ##2 (est_value_o == '0));
endmodule

bind freq_estimator fe_checker #(
  .CNT_W  (CNT_W),
  .CLR_CYC(1 << IDX_W)
) i_fe_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .est_valid_i(est_valid_i),
  .busy_o     (busy_o),
  .est_valid_o(est_valid_o),
  .est_value_o(est_value_o)
);

// File: tb/test_freq_estimator.sv
module test_freq_estimator;
  localparam int unsigned NB    = 5;
  localparam int unsigned CW    = 3;
  localparam int unsigned TH    = 6;
  localparam int unsigned LSB [NB] = '{0, 2, 4, 1, 3};
  localparam int unsigned WID [NB] = '{2, 2, 2, 3, 2};
  localparam int          MAXV  = (1 << CW) - 1;
  localparam int          DCLR  = 8;  // 2^max(WID)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_valid = 1'b0, est_valid = 1'b0;
  logic [31:0] inc_addr = '0, est_addr = '0;
  logic        busy, est_vo;
  logic [CW-1:0] est_val;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int m [NB][8];
  int tally = 0, rem = 0;
  bit m_busy = 0;
  bit p1v = 0, p2v = 0;
  int p1d = 0, p2d = 0;

  always #2.5 clk = ~clk;

  freq_estimator #(
    .ADDR_W(32), .CNT_W(CW), .SAT_THRESH(TH),
    .SLICE_LSB(LSB), .SLICE_W(WID)
  ) i_freq_estimator (
    .clk_i(clk), .rst_ni(rst_n),
    .inc_valid_i(inc_valid), .inc_addr_i(inc_addr),
    .est_valid_i(est_valid), .est_addr_i(est_addr),
    .busy_o(busy), .est_valid_o(est_vo), .est_value_o(est_val)
  );

  // R2: slice index per bank
  function automatic int sidx(int b, logic [31:0] a);
    return int'((a >> LSB[b]) & ((32'd1 << WID[b]) - 1));
  endfunction

  function automatic int mmin(logic [31:0] a);
    int r = MAXV + 1;
    for (int b = 0; b < NB; b++) if (m[b][sidx(b, a)] < r) r = m[b][sidx(b, a)];
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checks();
    check(busy == m_busy, "R9 busy_o", busy, m_busy);
    check(est_vo == p2v, "R3 est_valid_o", est_vo, p2v);
    if (p2v) check(int'(est_val) == p2d, "R4 est_value_o", est_val, p2d);
  endtask

  // drive at negedge, update model over the edge, check at next negedge
  task automatic cyc(bit iv, logic [31:0] ia, bit ev, logic [31:0] ea);
    bit acc;
    int e;
    inc_valid = iv; inc_addr = ia; est_valid = ev; est_addr = ea;
    acc = !m_busy;
    e = mmin(ea);  // R7: pre-increment value
    @(posedge clk);
    p2v = p1v; p2d = p1d;
    p1v = ev && acc; p1d = e;
    if (m_busy) begin
      // R10: requests ignored while clearing
      rem--;
      if (rem == 0) begin
        m_busy = 0;
        for (int b = 0; b < NB; b++) for (int i = 0; i < 8; i++) m[b][i] = 0;
      end
    end else if (iv) begin
      for (int b = 0; b < NB; b++) begin
        int k = sidx(b, ia);
        if (m[b][k] == MAXV - 1) tally++;    // R8
        if (m[b][k] < MAXV) m[b][k]++;       // R5, R6
      end
      if (tally >= TH) begin m_busy = 1; rem = DCLR; tally = 0; end
    end
    @(negedge clk);
    checks();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int i = 0; i < 8; i++) m[b][i] = 0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy_o", busy, 0);
    check(est_vo == 1'b0, "R1 est_valid_o", est_vo, 0);
    // R1, R4: all estimates zero
    for (int a = 0; a < 64; a++) cyc(0, 0, 1, a);
    // R5, R7: increment and estimate the same address together, then again
    for (int a = 0; a < 64; a++) begin
      cyc(1, a, 1, a);
      cyc(0, 0, 1, a);
    end
    for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0);
    // R6, R8: hammer one address past saturation; tally counts once per counter
    for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0);
    // saturate a disjoint set of counters to reach the threshold; R10 during sweep
    for (int i = 0; i < 30; i++) cyc(1, 63, 1, 63);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, i);
    // mixed traffic over a small address space
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r = $urandom;
      cyc(r[0] | r[1], {26'd0, r[7:2]}, r[8], {26'd0, r[14:9]});
    end
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0);
    finish_run();
  end
endmodule